// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block holds the tap position state for four digitally controlled resistor arrays. Every array owns one 6-bit wiper register and a set of four 6-bit data registers. The wiper register value is decoded into a one-hot select over 64 tap switches, so exactly one switch of each array is enabled at any time after reset.

A host issues commands through a valid/ready command port. Each command carries a 3-bit operation code, a 2-bit array index, a 2-bit data register index and a 6-bit payload. A command can write or read a wiper register, write or read a data register, or copy one of the array's data registers into its wiper register. Read results are returned on a separate valid/ready response port, registered one cycle after the command is taken.

Back-pressure rules: a command transfers on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever no response is waiting, or when the waiting response is handed off in the same cycle (`rsp_ready` high). A response transfers on an edge where `rsp_valid` and `rsp_ready` are both high. While a response is held back, `rsp_data` does not change and no command is taken.

Top module: `quad_wiper_bank`

## Requirements
- R1: After reset every wiper register and every data register is 0, each array's 64-bit tap slice equals 1 (tap 0), `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: An accepted command with `cmd_op` = 1 loads `cmd_data` into the wiper of array `cmd_arr`; from the next cycle that array's tap slice `tap_sel[64*a +: 64]` has only bit `cmd_data` set, and the other arrays' slices are unchanged.
- R3: An accepted command with `cmd_op` = 3 loads `cmd_data` into data register `cmd_reg` of array `cmd_arr` and leaves every tap slice unchanged.
- R4: An accepted command with `cmd_op` = 5 copies data register `cmd_reg` of array `cmd_arr` into that array's wiper; the tap slice follows from the next cycle.
- R5: An accepted command with `cmd_op` = 2 (wiper) or `cmd_op` = 4 (data register `cmd_reg`) of array `cmd_arr` raises `rsp_valid` on the next cycle with the register's value, as it stood when the command was taken, on `rsp_data`.
- R6: While `rsp_valid` is 1 and `rsp_ready` is 0, `cmd_ready` is 0, no command takes effect, and `rsp_valid` and `rsp_data` hold; when `rsp_ready` rises, a held command is taken in the same cycle as the response hand-off.
- R7: Operation codes 0, 6 and 7 change no register and produce no response.
- R8: Each array's 64-bit tap slice has exactly one bit set in every cycle after reset.
- R9: A cycle with `cmd_valid` low changes no register, whatever the other command inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Operation: 0 none, 1 write wiper, 2 read wiper, 3 write data reg, 4 read data reg, 5 copy data reg to wiper |
| cmd_arr | input | 2 | Target array index |
| cmd_reg | input | 2 | Data register index within the array |
| cmd_data | input | 6 | Write payload |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Host takes the read result |
| rsp_data | output | 6 | Read result |
| tap_sel | output | 256 | One-hot tap selects, 64 bits per array, array 0 in the low bits |

## Verification
The two functions that can share a clock edge are the hand-off of a waiting read result and the acceptance of the next command. The bench stalls the response port after a read, keeps a wiper write presented while `cmd_ready` is low, then raises `rsp_ready`; it judges that the write lands on exactly that edge, that the stalled result never changed, and that no stale result remains. A second case streams two reads back to back with the response port always ready, so one result drains on the same edge the next read is taken, and checks both values in order.

// File: rtl/qwb_pkg.sv
package qwb_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE     = 3'd0,
    OP_SET_WIP  = 3'd1,
    OP_GET_WIP  = 3'd2,
    OP_SET_DR   = 3'd3,
    OP_GET_DR   = 3'd4,
    OP_DR2WIP   = 3'd5
  } qwb_op_e;
endpackage

// File: rtl/qwb_cmd_decode.sv
module qwb_cmd_decode
  import qwb_pkg::*;
#(
  parameter int NUM_ARR = 4,
  parameter int ARR_W   = 2
) (
  input  logic               take,
  input  logic [OP_W-1:0]    op,
  input  logic [ARR_W-1:0]   arr,
  output logic [NUM_ARR-1:0] set_wip,
  output logic [NUM_ARR-1:0] set_dr,
  output logic [NUM_ARR-1:0] dr2wip,
  output logic               get_wip,
  output logic               get_dr
);
  logic [NUM_ARR-1:0] arr_hot;
  logic is_set_wip, is_set_dr, is_copy;

  for (genvar g = 0; g < NUM_ARR; g++) begin : g_hit
    assign arr_hot[g] = (arr == ARR_W'(g));
  end

  always_comb begin
    is_set_wip = 1'b0;
    is_set_dr  = 1'b0;
    is_copy    = 1'b0;
    get_wip    = 1'b0;
    get_dr     = 1'b0;
    if (take) begin
      case (qwb_op_e'(op))
        OP_SET_WIP: is_set_wip = 1'b1;
        OP_GET_WIP: get_wip    = 1'b1;
        OP_SET_DR:  is_set_dr  = 1'b1;
        OP_GET_DR:  get_dr     = 1'b1;
        OP_DR2WIP:  is_copy    = 1'b1;
        default:    ;
      endcase
    end
  end

  assign set_wip = arr_hot & {NUM_ARR{is_set_wip}};
  assign set_dr  = arr_hot & {NUM_ARR{is_set_dr}};
  assign dr2wip  = arr_hot & {NUM_ARR{is_copy}};
endmodule

// File: rtl/qwb_array_regs.sv
module qwb_array_regs #(
  parameter int WIPER_W = 6,
  parameter int NUM_DR  = 4,
  parameter int REG_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      set_wip,
  input  logic                      set_dr,
  input  logic                      dr2wip,
  input  logic [REG_W-1:0]          reg_sel,
  input  logic [WIPER_W-1:0]        wdata,
  output logic [WIPER_W-1:0]        wiper,
  output logic [NUM_DR*WIPER_W-1:0] dr_flat
);
  logic [WIPER_W-1:0] dr_q [NUM_DR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DR; i++) dr_q[i] <= '0;
    end else if (set_dr) begin
      dr_q[reg_sel] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper <= '0;
    end else if (set_wip) begin
      wiper <= wdata;
    end else if (dr2wip) begin
      wiper <= dr_q[reg_sel];
    end
  end

  for (genvar g = 0; g < NUM_DR; g++) begin : g_flat
    assign dr_flat[g*WIPER_W +: WIPER_W] = dr_q[g];
  end
endmodule

// File: rtl/qwb_tap_decode.sv
module qwb_tap_decode #(
  parameter int WIPER_W = 6,
  localparam int TAPS   = 1 << WIPER_W
) (
  input  logic [WIPER_W-1:0] wiper,
  output logic [TAPS-1:0]    sel
);
  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign sel[g] = (wiper == WIPER_W'(g));
  end
endmodule

// File: rtl/qwb_rsp_stage.sv
module qwb_rsp_stage #(
  parameter int NUM_ARR = 4,
  parameter int NUM_DR  = 4,
  parameter int WIPER_W = 6,
  parameter int ARR_W   = 2,
  parameter int REG_W   = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              get_wip,
  input  logic                              get_dr,
  input  logic [ARR_W-1:0]                  arr,
  input  logic [REG_W-1:0]                  reg_sel,
  input  logic [NUM_ARR*WIPER_W-1:0]        wip_flat,
  input  logic [NUM_ARR*NUM_DR*WIPER_W-1:0] dr_flat,
  input  logic                              rsp_ready,
  output logic                              rsp_valid,
  output logic [WIPER_W-1:0]                rsp_data
);
  logic [WIPER_W-1:0] pick;

  always_comb begin
    if (get_dr)
      pick = dr_flat[(int'(arr)*NUM_DR + int'(reg_sel))*WIPER_W +: WIPER_W];
    else
      pick = wip_flat[int'(arr)*WIPER_W +: WIPER_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (get_wip || get_dr) begin
      rsp_valid <= 1'b1;
      rsp_data  <= pick;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/quad_wiper_bank.sv
module quad_wiper_bank
  import qwb_pkg::*;
#(
  parameter int NUM_ARR = 4,
  parameter int NUM_DR  = 4,
  parameter int WIPER_W = 6,
  localparam int ARR_W  = $clog2(NUM_ARR),
  localparam int REG_W  = $clog2(NUM_DR),
  localparam int TAPS   = 1 << WIPER_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [OP_W-1:0]         cmd_op,
  input  logic [ARR_W-1:0]        cmd_arr,
  input  logic [REG_W-1:0]        cmd_reg,
  input  logic [WIPER_W-1:0]      cmd_data,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [WIPER_W-1:0]      rsp_data,
  output logic [NUM_ARR*TAPS-1:0] tap_sel
);
  logic                              take;
  logic [NUM_ARR-1:0]                set_wip, set_dr, dr2wip;
  logic                              get_wip, get_dr;
  logic [NUM_ARR*WIPER_W-1:0]        wip_flat;
  logic [NUM_ARR*NUM_DR*WIPER_W-1:0] dr_flat;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign take      = cmd_valid && cmd_ready;

  qwb_cmd_decode #(.NUM_ARR(NUM_ARR), .ARR_W(ARR_W)) u_dec (
    .take(take), .op(cmd_op), .arr(cmd_arr),
    .set_wip(set_wip), .set_dr(set_dr), .dr2wip(dr2wip),
    .get_wip(get_wip), .get_dr(get_dr)
  );

  for (genvar g = 0; g < NUM_ARR; g++) begin : g_arr
    qwb_array_regs #(.WIPER_W(WIPER_W), .NUM_DR(NUM_DR), .REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .set_wip(set_wip[g]), .set_dr(set_dr[g]), .dr2wip(dr2wip[g]),
      .reg_sel(cmd_reg), .wdata(cmd_data),
      .wiper(wip_flat[g*WIPER_W +: WIPER_W]),
      .dr_flat(dr_flat[g*NUM_DR*WIPER_W +: NUM_DR*WIPER_W])
    );
    qwb_tap_decode #(.WIPER_W(WIPER_W)) u_tap (
      .wiper(wip_flat[g*WIPER_W +: WIPER_W]),
      .sel(tap_sel[g*TAPS +: TAPS])
    );
  end

  qwb_rsp_stage #(
    .NUM_ARR(NUM_ARR), .NUM_DR(NUM_DR), .WIPER_W(WIPER_W),
    .ARR_W(ARR_W), .REG_W(REG_W)
  ) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .get_wip(get_wip), .get_dr(get_dr),
    .arr(cmd_arr), .reg_sel(cmd_reg),
    .wip_flat(wip_flat), .dr_flat(dr_flat),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/qwb_checker.sv
module qwb_checker
  import qwb_pkg::*;
#(
  parameter int NUM_ARR = 4,
  parameter int WIPER_W = 6,
  parameter int ARR_W   = 2,
  localparam int TAPS   = 1 << WIPER_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic                    cmd_ready,
  input logic [OP_W-1:0]         cmd_op,
  input logic [ARR_W-1:0]        cmd_arr,
  input logic [WIPER_W-1:0]      cmd_data,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic [WIPER_W-1:0]      rsp_data,
  input logic [NUM_ARR*TAPS-1:0] tap_sel
);
  logic took, took_rd;
  assign took    = cmd_valid && cmd_ready;
  assign took_rd = took && (cmd_op == OP_GET_WIP || cmd_op == OP_GET_DR);

  for (genvar g = 0; g < NUM_ARR; g++) begin : g_oh
    assert_tap_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel[g*TAPS +: TAPS]) == 1);
  end

  assert_wip_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (took && cmd_op == OP_SET_WIP) |=>
      tap_sel[int'($past(cmd_arr))*TAPS +: TAPS] == (TAPS'(1) << $past(cmd_data)));

  assert_dr_write_taps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (took && cmd_op == OP_SET_DR) |=> $stable(tap_sel));

  assert_read_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    took_rd |=> rsp_valid);

  assert_stall_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_no_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!took_rd && (!rsp_valid || rsp_ready)) |=> !rsp_valid);

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !took |=> $stable(tap_sel));
endmodule

bind quad_wiper_bank qwb_checker #(
  .NUM_ARR(NUM_ARR), .WIPER_W(WIPER_W), .ARR_W(ARR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_arr(cmd_arr), .cmd_data(cmd_data),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .tap_sel(tap_sel)
);

// File: tb/sim_quad_wiper_bank.sv
module sim_quad_wiper_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [2:0]   cmd_op = 3'd0;
  logic [1:0]   cmd_arr = 2'd0;
  logic [1:0]   cmd_reg = 2'd0;
  logic [5:0]   cmd_data = 6'd0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [5:0]   rsp_data;
  logic [255:0] tap_sel;

  int checks = 0;
  int errors = 0;
  logic [5:0] m_wip [4];
  logic [5:0] m_dr [4][4];

  always #2 clk = ~clk;

  quad_wiper_bank u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arr(cmd_arr), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .tap_sel(tap_sel)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] onehot(input logic [5:0] v);
    return 64'd1 << v;
  endfunction

  task automatic check_taps(input string tag);
    for (int a = 0; a < 4; a++)
      check(tap_sel[a*64 +: 64] == onehot(m_wip[a]), tag,
            tap_sel[a*64 +: 64], onehot(m_wip[a]));
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] arr,
                       input logic [1:0] rs, input logic [5:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_arr = arr; cmd_reg = rs; cmd_data = d;
  endtask

  task automatic idle();
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic send(input logic [2:0] op, input logic [1:0] arr,
                      input logic [1:0] rs, input logic [5:0] d);
    @(negedge clk); drive(op, arr, rs, d);
    @(negedge clk); idle();
  endtask

  task automatic read_chk(input logic [2:0] op, input logic [1:0] arr,
                          input logic [1:0] rs, input logic [5:0] exp, input string tag);
    @(negedge clk); drive(op, arr, rs, 6'd0);
    @(negedge clk); idle();
    check(rsp_valid == 1'b1, {tag, " valid"}, 64'(rsp_valid), 64'd1);
    check(rsp_data == exp, {tag, " data"}, 64'(rsp_data), 64'(exp));
    @(negedge clk);
    check(rsp_valid == 1'b0, {tag, " drained"}, 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset();
    check(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check(cmd_ready == 1'b1, "R1 cmd_ready", 64'(cmd_ready), 64'd1);
    check_taps("R1 taps at 0");
    for (int a = 0; a < 4; a++)
      for (int r = 0; r < 4; r++)
        read_chk(3'd4, 2'(a), 2'(r), 6'd0, "R1 R5 data reg zero");
  endtask

  task automatic t_set_wiper();
    logic [5:0] vals [4] = '{6'd63, 6'd1, 6'd32, 6'd17};
    for (int a = 0; a < 4; a++) begin
      send(3'd1, 2'(a), 2'd3, vals[a]);
      m_wip[a] = vals[a];
      check_taps("R2 R8 wiper write");
    end
    send(3'd1, 2'd0, 2'd0, 6'd0);
    m_wip[0] = 6'd0;
    check_taps("R2 wiper write to 0");
    for (int a = 0; a < 4; a++)
      read_chk(3'd2, 2'(a), 2'd0, m_wip[a], "R5 wiper read");
  endtask

  task automatic t_set_dr();
    for (int a = 0; a < 4; a++)
      for (int r = 0; r < 4; r++) begin
        send(3'd3, 2'(a), 2'(r), 6'(a*16 + r*5 + 3));
        m_dr[a][r] = 6'(a*16 + r*5 + 3);
      end
    check_taps("R3 taps untouched by data writes");
    for (int a = 0; a < 4; a++)
      for (int r = 0; r < 4; r++)
        read_chk(3'd4, 2'(a), 2'(r), m_dr[a][r], "R3 R5 data reg read");
  endtask

  task automatic t_copy();
    send(3'd5, 2'd2, 2'd3, 6'd0);
    m_wip[2] = m_dr[2][3];
    check_taps("R4 copy reg3 to wiper2");
    send(3'd5, 2'd0, 2'd1, 6'd55);
    m_wip[0] = m_dr[0][1];
    check_taps("R4 copy reg1 to wiper0, payload ignored");
    read_chk(3'd2, 2'd2, 2'd0, m_wip[2], "R4 copied wiper read");
  endtask

  task automatic t_ignored();
    send(3'd0, 2'd1, 2'd1, 6'd44);
    check(rsp_valid == 1'b0, "R7 op0 no response", 64'(rsp_valid), 64'd0);
    send(3'd6, 2'd1, 2'd1, 6'd44);
    check(rsp_valid == 1'b0, "R7 op6 no response", 64'(rsp_valid), 64'd0);
    send(3'd7, 2'd3, 2'd2, 6'd44);
    check(rsp_valid == 1'b0, "R7 op7 no response", 64'(rsp_valid), 64'd0);
    check_taps("R7 taps unchanged");
    read_chk(3'd4, 2'd1, 2'd1, m_dr[1][1], "R7 data reg unchanged");
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd1; cmd_arr = 2'd3; cmd_data = 6'd9;
    @(negedge clk);
    cmd_op = 3'd3; cmd_reg = 2'd2;
    @(negedge clk); idle();
    check_taps("R9 invalid cycles ignored");
    read_chk(3'd4, 2'd3, 2'd2, m_dr[3][2], "R9 data reg unchanged");
  endtask

  task automatic t_stall();
    logic [5:0] held;
    rsp_ready = 1'b0;
    @(negedge clk); drive(3'd2, 2'd1, 2'd0, 6'd0);
    @(negedge clk);
    held = m_wip[1];
    check(rsp_valid && rsp_data == held, "R6 stalled read", 64'(rsp_data), 64'(held));
    drive(3'd1, 2'd1, 2'd0, 6'd9);
    #0;
    check(cmd_ready == 1'b0, "R6 cmd_ready low", 64'(cmd_ready), 64'd0);
    repeat (3) @(negedge clk);
    check(rsp_valid && rsp_data == held, "R6 response held", 64'(rsp_data), 64'(held));
    check_taps("R6 write blocked during stall");
    rsp_ready = 1'b1;
    @(negedge clk); idle();
    m_wip[1] = 6'd9;
    check(rsp_valid == 1'b0, "R6 hand-off cleared", 64'(rsp_valid), 64'd0);
    check_taps("R6 write taken on hand-off edge");
    @(negedge clk); drive(3'd2, 2'd3, 2'd0, 6'd0);
    @(negedge clk);
    check(rsp_data == m_wip[3], "R5 stream first", 64'(rsp_data), 64'(m_wip[3]));
    drive(3'd4, 2'd2, 2'd1, 6'd0);
    @(negedge clk); idle();
    check(rsp_valid && rsp_data == m_dr[2][1], "R5 stream second",
          64'(rsp_data), 64'(m_dr[2][1]));
    @(negedge clk);
    check(rsp_valid == 1'b0, "R5 stream drained", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    for (int a = 0; a < 4; a++) begin
      m_wip[a] = 6'd0;
      for (int r = 0; r < 4; r++) m_dr[a][r] = 6'd0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_wiper();
    t_set_dr();
    t_copy();
    t_ignored();
    t_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule